// File: doc/BRIEF.md
# LFO Amplitude and Pitch Modulation Generator

This block is a low-frequency oscillator for a sound synthesis voice. On every clock, which counts as one sample, it adds a programmable increment to a fixed-point phase counter. The integer part of the counter is a 7-bit index. From that index the block derives two modulation values. The first is an amplitude-modulation (AM) depth, shaped as a triangle. The second is a coarse pitch-modulation (PM) step. Each of the two registered values changes only on a sample where the counter field it depends on changes.

The block also applies the AM depth to the attenuation of each operator. For each operator it takes a mask bit, and it uses one shared 2-bit sensitivity. The sensitivity sets how far the AM depth is scaled down before it is added to the attenuation. Bit 0 of every modulated attenuation is cleared. When the oscillator is disabled, the counter holds its value, both modulation outputs drop to zero, and the attenuations pass through unchanged apart from the cleared bit 0. Applying the pitch step to phase increments is the job of a separate block.

Top module: `lfo_mod_gen`

## Requirements
- R1: After reset, am_val and pm_step are 0. The internal phase counter is 0.
- R2: While lfo_en is 1, each clock adds lfo_inc to a 32-bit counter, wrapping modulo 2^32. The index is bits [FRAC_W+6:FRAC_W] of the counter, with FRAC_W = 16 by default.
- R3: On a clock where the index changes, am_val becomes 2*((idx & 63) ^ (idx < 64 ? 63 : 0)). This value is always even and lies in 0..126.
- R4: On an enabled clock where the index does not change, am_val keeps its value. In particular it stays at 0 after reset until the index first moves.
- R5: pm_step is idx >> 2 (5 bits). It is rewritten only on a clock where idx >> 2 changes, and otherwise keeps its value.
- R6: A clock with lfo_en = 0 sets am_val and pm_step to 0 and leaves the counter unchanged. After re-enabling, the index continues from the held count.
- R7: For operator k with lfo_en = 1 and am_mask[k] = 1, att_out[k] = (att_in[k] + (am_val >> s)) with bit 0 cleared. Here s is 3, 1 or 0 for am_sens 1, 2 or 3, and am_sens = 0 adds nothing. Operator k occupies att_in bits [k*10 +: 10] and att_out bits [k*11 +: 11].
- R8: For an operator with am_mask[k] = 0, or whenever lfo_en = 0, att_out[k] equals att_in[k] zero-extended to 11 bits with bit 0 cleared.
- R9: Bit 0 of every att_out slice is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per sample |
| rst_n | input | 1 | Active-low synchronous reset |
| lfo_en | input | 1 | Oscillator enable |
| lfo_inc | input | 32 | Counter increment per sample (16.16 by default) |
| am_sens | input | 2 | AM sensitivity: 0 none, 1 shift 3, 2 shift 1, 3 shift 0 |
| am_mask | input | 4 | Per-operator AM enable |
| att_in | input | 40 | Four 10-bit operator attenuations |
| am_val | output | 7 | Doubled triangle AM depth |
| pm_step | output | 5 | Pitch-modulation step, index/4 |
| att_out | output | 44 | Four 11-bit modulated attenuations |

## Verification
The states that are hardest to reach are the ones where the counter moves but the index does not, so that AM and PM must hold stale values. The clearest case is AM staying at 0 after reset or re-enable, even though the fold of index 0 would give 126. The bench reaches these states with fractional increments smaller than one index step, and with quarter steps that change the index on only some clocks. It drives the counter across its 32-bit wrap with an increment equal to minus one index step, which walks the triangle downward. The bench also disables the oscillator in the middle of a sweep to show that the count resumes from where it stopped.

// File: rtl/lfo_mod_pkg.sv
package lfo_mod_pkg;

   // Right-shift applied to the AM depth for sensitivity codes 1..3
   function automatic logic [1:0] sens_to_shift(input logic [1:0] sens);
      case (sens)
         2'd1:    return 2'd3;
         2'd2:    return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/lfo_phase_acc.sv
module lfo_phase_acc #(
   parameter int CNT_W  = 32,
   parameter int FRAC_W = 16,
   parameter int IDX_W  = 7,
   parameter int PM_SH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] inc,
   output logic [IDX_W-1:0] idx_nxt,
   output logic             idx_chg,
   output logic             pm_chg
);
   localparam int PM_W = IDX_W - PM_SH;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_sum;
   logic [IDX_W-1:0] idx_cur;
   logic [PM_W-1:0]  q_cur, q_nxt;

   assign cnt_sum = cnt_q + inc;
   assign idx_cur = cnt_q[FRAC_W +: IDX_W];
   assign idx_nxt = cnt_sum[FRAC_W +: IDX_W];
   assign q_cur   = idx_cur[IDX_W-1:PM_SH];
   assign q_nxt   = idx_nxt[IDX_W-1:PM_SH];
   assign idx_chg = en && (idx_nxt != idx_cur);
   assign pm_chg  = en && (q_nxt != q_cur);

   always_ff @(posedge clk) begin
      if (!rst_n)  cnt_q <= '0;
      else if (en) cnt_q <= cnt_sum;
   end

   // R6
   hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt_q));

   // R5
   pm_implies_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_chg |-> idx_chg);

endmodule

// File: rtl/lfo_wave_gen.sv
module lfo_wave_gen #(
   parameter int IDX_W = 7,
   parameter int PM_SH = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [IDX_W-1:0]       idx_nxt,
   input  logic                   idx_chg,
   input  logic                   pm_chg,
   output logic [IDX_W-1:0]       am,
   output logic [IDX_W-PM_SH-1:0] pm
);
   localparam int HALF_W = IDX_W - 1;

   logic [HALF_W-1:0] fold;

   // Rising half for the upper index range, mirrored for the lower range
   assign fold = idx_nxt[IDX_W-1] ? idx_nxt[HALF_W-1:0] : ~idx_nxt[HALF_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         am <= '0;
         pm <= '0;
      end else begin
         if (idx_chg) am <= {fold, 1'b0};
         if (pm_chg)  pm <= idx_nxt[IDX_W-1:PM_SH];
      end
   end

   // R4
   am_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !idx_chg) |=> $stable(am));

   // R5
   pm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !pm_chg) |=> $stable(pm));

   // R6
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (am == '0 && pm == '0));

   // R3
   am_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      am[0] == 1'b0);

endmodule

// File: rtl/lfo_am_apply.sv
module lfo_am_apply
   import lfo_mod_pkg::*;
#(
   parameter int AM_W  = 7,
   parameter int ATT_W = 10
) (
   input  logic             en,
   input  logic             mask_bit,
   input  logic [1:0]       sens,
   input  logic [AM_W-1:0]  am,
   input  logic [ATT_W-1:0] att_in,
   output logic [ATT_W:0]   att_out
);
   logic [AM_W-1:0] amt;
   logic [ATT_W:0]  sum;

   always_comb begin
      if (en && mask_bit && sens != 2'd0) amt = am >> sens_to_shift(sens);
      else                                amt = '0;
   end

   assign sum     = {1'b0, att_in} + (ATT_W+1)'(amt);
   assign att_out = {sum[ATT_W:1], 1'b0};

endmodule

// File: rtl/lfo_mod_gen.sv
module lfo_mod_gen #(
   parameter int CNT_W  = 32,
   parameter int FRAC_W = 16,
   parameter int IDX_W  = 7,
   parameter int PM_SH  = 2,
   parameter int NOPS   = 4,
   parameter int ATT_W  = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      lfo_en,
   input  logic [CNT_W-1:0]          lfo_inc,
   input  logic [1:0]                am_sens,
   input  logic [NOPS-1:0]           am_mask,
   input  logic [NOPS*ATT_W-1:0]     att_in,
   output logic [IDX_W-1:0]          am_val,
   output logic [IDX_W-PM_SH-1:0]    pm_step,
   output logic [NOPS*(ATT_W+1)-1:0] att_out
);
   localparam int OUT_W = ATT_W + 1;
   localparam int AM_MAX = (1 << IDX_W) - 2;

   if (FRAC_W + IDX_W > CNT_W) begin : g_bad_cnt
      $error("index field does not fit in the counter");
   end
   if (IDX_W < 3 || PM_SH < 1 || PM_SH >= IDX_W) begin : g_bad_idx
      $error("index width or PM shift out of range");
   end
   if (IDX_W > OUT_W) begin : g_bad_att
      $error("attenuation too narrow for AM depth");
   end

   logic [IDX_W-1:0] idx_nxt;
   logic             idx_chg, pm_chg;

   lfo_phase_acc #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W), .PM_SH(PM_SH)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (lfo_en),
      .inc     (lfo_inc),
      .idx_nxt (idx_nxt),
      .idx_chg (idx_chg),
      .pm_chg  (pm_chg)
   );

   lfo_wave_gen #(.IDX_W(IDX_W), .PM_SH(PM_SH)) u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (lfo_en),
      .idx_nxt (idx_nxt),
      .idx_chg (idx_chg),
      .pm_chg  (pm_chg),
      .am      (am_val),
      .pm      (pm_step)
   );

   for (genvar g = 0; g < NOPS; g++) begin : g_op
      logic [ATT_W-1:0] a_in;
      logic [OUT_W-1:0] a_out;

      assign a_in = att_in[g*ATT_W +: ATT_W];

      lfo_am_apply #(.AM_W(IDX_W), .ATT_W(ATT_W)) u_apply (
         .en       (lfo_en),
         .mask_bit (am_mask[g]),
         .sens     (am_sens),
         .am       (am_val),
         .att_in   (a_in),
         .att_out  (a_out)
      );

      assign att_out[g*OUT_W +: OUT_W] = a_out;

      // R8
      pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!lfo_en || !am_mask[g]) |-> (a_out[OUT_W-1:1] == {1'b0, a_in[ATT_W-1:1]}));

      // R9
      lsb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         a_out[0] == 1'b0);

      // R7
      am_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (a_out >= {1'b0, a_in[ATT_W-1:1], 1'b0}) &&
         (a_out <= {1'b0, a_in} + OUT_W'(AM_MAX)));
   end

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (am_val == '0 && pm_step == '0));

endmodule

// File: tb/tb_lfo_mod_gen.sv
module tb_lfo_mod_gen;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        lfo_en;
   logic [31:0] lfo_inc;
   logic [1:0]  am_sens;
   logic [3:0]  am_mask;
   logic [39:0] att_in;
   logic [6:0]  am_val;
   logic [4:0]  pm_step;
   logic [43:0] att_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [31:0] m_cnt;
   int          m_am, m_pm;

   always #2 clk = ~clk;

   lfo_mod_gen dut (
      .clk(clk), .rst_n(rst_n), .lfo_en(lfo_en), .lfo_inc(lfo_inc),
      .am_sens(am_sens), .am_mask(am_mask), .att_in(att_in),
      .am_val(am_val), .pm_step(pm_step), .att_out(att_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int fold2(input int i);
      return 2 * ((i & 63) ^ ((i < 64) ? 63 : 0));
   endfunction

   // Model of the counter and the AM/PM registers (R2, R3, R4, R5, R6)
   task automatic model_edge();
      logic [31:0] nc;
      int oi, ni;
      if (!rst_n) begin
         m_cnt = 0; m_am = 0; m_pm = 0;
      end else if (!lfo_en) begin
         m_am = 0; m_pm = 0;
      end else begin
         nc = m_cnt + lfo_inc;
         oi = int'(m_cnt[22:16]);
         ni = int'(nc[22:16]);
         if (ni != oi) m_am = fold2(ni);
         if ((ni >> 2) != (oi >> 2)) m_pm = ni >> 2;
         m_cnt = nc;
      end
   endtask

   task automatic check_outputs(input string am_tag, input string pm_tag);
      chk(int'(am_val) == m_am, am_tag, int'(am_val), m_am);
      chk(int'(pm_step) == m_pm, pm_tag, int'(pm_step), m_pm);
      for (int k = 0; k < 4; k++) begin
         int a, amt, e, sh;
         a  = int'(att_in[k*10 +: 10]);
         sh = (am_sens == 2'd1) ? 3 : (am_sens == 2'd2) ? 1 : 0;
         amt = (lfo_en && am_mask[k] && am_sens != 2'd0) ? (m_am >> sh) : 0;
         e  = (a + amt) & 32'h7FE;
         // R7 when applied, R8 when masked or disabled, R9 bit 0
         chk(int'(att_out[k*11 +: 11]) == e,
             (amt == 0) ? "R8 att pass" : "R7 att mod", int'(att_out[k*11 +: 11]), e);
      end
   endtask

   task automatic step(input string am_tag, input string pm_tag);
      @(posedge clk);
      model_edge();
      #1;
      check_outputs(am_tag, pm_tag);
   endtask

   initial begin
      #400000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; lfo_en = 1'b0; lfo_inc = '0;
      am_sens = 2'd3; am_mask = 4'hF; att_in = '0;
      repeat (3) step("R1 am reset", "R1 pm reset");
      rst_n = 1'b1;
      att_in = {10'd1023, 10'd513, 10'd2, 10'd7};
      step("R1 am idle", "R1 pm idle");

      // R4: sub-step increments never move the index, so AM stays 0
      lfo_en = 1'b1; lfo_inc = 32'h0000_0100;
      for (int i = 0; i < 20; i++) step("R4 am held at zero", "R5 pm held");

      // R3/R5: one index step per clock over a full period and more
      lfo_inc = 32'h0001_0000;
      for (int i = 0; i < 140; i++) begin
         am_sens = 2'(i % 4);
         att_in = {10'($urandom), 10'($urandom), 10'($urandom), 10'($urandom)};
         step("R3 am fold", "R5 pm step");
      end

      // R4/R5: quarter steps, index changes on some clocks only
      lfo_inc = 32'h0000_4000;
      for (int i = 0; i < 300; i++) step("R4 am hold", "R5 pm hold");

      // R2: minus one step wraps the 32-bit counter and walks downward
      lfo_inc = 32'hFFFF_0000;
      for (int i = 0; i < 140; i++) step("R2 wrap am", "R2 wrap pm");

      // R6: disable clears outputs and holds the counter
      lfo_en = 1'b0;
      for (int i = 0; i < 6; i++) step("R6 am off", "R6 pm off");
      lfo_en = 1'b1; lfo_inc = 32'h0001_8000;
      for (int i = 0; i < 40; i++) step("R6 am resume", "R6 pm resume");

      // R7/R8: every mask, sensitivity and enable combination
      lfo_inc = 32'h0000_C000;
      for (int m = 0; m < 16; m++) begin
         for (int s = 0; s < 4; s++) begin
            am_mask = 4'(m); am_sens = 2'(s);
            lfo_en = (s != 0 || m[0]);
            att_in = {10'($urandom), 10'($urandom), 10'($urandom), 10'($urandom)};
            step("R7 am sweep", "R5 pm sweep");
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule